// File: doc/BRIEF.md
# Polled Two-Wire Serial Frame Port

This block connects a two-wire asynchronous serial line (one data wire in each direction, no handshake pins) to a byte-wide frame interface on the system side. Bytes that the endpoint sends are recovered from the line, unescaped according to SLIP framing and passed on, each frame closed by an end pulse. Frames from the system side are stored whole in an internal buffer. They are never sent on their own initiative.

Outgoing traffic is polled in-band. Every raw 0xC0 byte that the endpoint sends counts as a query. The block answers each query with exactly one reply. If a complete frame is waiting, the reply is that frame, SLIP-escaped and closed with 0xC0. If no frame is waiting, the reply is a lone 0xC0. Queries that arrive while a reply is still on the wire are held in a small saturating counter and answered one by one afterwards. The bit period is a runtime input. For example, a 100 MHz clock with a divider of 109 gives about 921600 baud, and smaller dividers reach about 4 Mbaud.

Top module: `uart2_query_port`

## Requirements
- R1: The transmitter sends each byte as one low start bit, eight data bits with the least significant bit first, and one high stop bit, each bit lasting `baud_div` clock cycles. The line rests high between bytes.
- R2: The receiver recovers 8N1 bytes at `baud_div` clocks per bit. The pairs 0xDB 0xDC and 0xDB 0xDD appear on `rcv_data_o` as 0xC0 and 0xDB. A received raw 0xC0 that follows at least one data byte pulses `rcv_eof_o` for one cycle.
- R3: Every raw 0xC0 received counts as one query. An escaped 0xC0 (0xDB 0xDC) never counts as a query.
- R4: A query served while a complete frame is buffered sends that frame. In the reply, a data byte 0xC0 becomes 0xDB 0xDC, a data byte 0xDB becomes 0xDB 0xDD, and one 0xC0 follows the last byte. No 0xC0 precedes the frame.
- R5: A query served while no complete frame is buffered sends a single 0xC0.
- R6: A frame whose last byte has not yet been written is not sent. A query in that state is answered as in R5.
- R7: Queries that arrive during a reply are counted up to `QMAX` and served one at a time after it. Any further queries in that time are discarded.
- R8: A frame that does not fit in the free buffer space is discarded whole. `snd_drop_o` pulses for one cycle when its last byte is offered. Frames buffered before it and frames written after it are not affected.
- R9: During and right after reset, `tx_line_o` is high and `rcv_valid_o`, `rcv_eof_o` and `snd_drop_o` are low.
- R10: A new value of `baud_div`, applied while the line is idle, sets the bit period for both directions from the next byte onwards.
- R11: Buffered frames are sent in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Clock cycles per bit, at least 4 |
| rx_line_i | input | 1 | Serial data from the endpoint |
| tx_line_o | output | 1 | Serial data to the endpoint |
| rcv_data_o | output | 8 | Unescaped received data byte |
| rcv_valid_o | output | 1 | `rcv_data_o` is valid for this cycle |
| rcv_eof_o | output | 1 | Pulse: the received frame has ended |
| snd_data_i | input | 8 | Outgoing frame byte |
| snd_valid_i | input | 1 | `snd_data_i` is offered this cycle |
| snd_last_i | input | 1 | The offered byte ends its frame |
| snd_drop_o | output | 1 | Pulse: an outgoing frame was discarded |

## Verification
The bench builds the block with `DEPTH=16` and `QMAX=2`. A 16-byte buffer lets a 20-byte frame overflow in one scenario. With a limit of two, four queries sent back to back during a long reply push the counter into saturation, so the discarded query shows up as a missing reply. Most traffic runs at 8 clocks per bit to keep the run short. A final scenario switches to 12 clocks per bit to check that both directions follow the runtime divider.

// File: rtl/uq_pkg.sv
package uq_pkg;
   localparam logic [7:0] SLIP_END     = 8'hC0;
   localparam logic [7:0] SLIP_ESC     = 8'hDB;
   localparam logic [7:0] SLIP_ESC_END = 8'hDC;
   localparam logic [7:0] SLIP_ESC_ESC = 8'hDD;

   typedef enum logic [1:0] {
      RP_IDLE = 2'd0,
      RP_DATA = 2'd1,
      RP_ESC  = 2'd2,
      RP_END  = 2'd3
   } reply_st_t;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_st_t;
endpackage

// File: rtl/uq_uart_rx.sv
module uq_uart_rx
   import uq_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic             line_i,
   output logic [7:0]       data_o,
   output logic             valid_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uq_uart_rx: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_s;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b1;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end
   assign line_s = sync_q[SYNC_STAGES-1];

   rx_st_t           st_q;
   logic [DIV_W-1:0] cnt_q;
   logic [2:0]       bit_q;
   logic [7:0]       sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         data_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         case (st_q)
            RX_IDLE: begin
               if (!line_s) begin
                  cnt_q <= '0;
                  st_q  <= RX_START;
               end
            end
            RX_START: begin
               if (cnt_q == (div_i >> 1)) begin
                  cnt_q <= '0;
                  bit_q <= '0;
                  st_q  <= line_s ? RX_IDLE : RX_DATA;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            RX_DATA: begin
               if (cnt_q == div_i - 1'b1) begin
                  cnt_q <= '0;
                  sh_q  <= {line_s, sh_q[7:1]};
                  bit_q <= bit_q + 1'b1;
                  if (bit_q == 3'd7) st_q <= RX_STOP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               if (cnt_q == div_i - 1'b1) begin
                  cnt_q <= '0;
                  st_q  <= RX_IDLE;
                  if (line_s) begin
                     data_o  <= sh_q;
                     valid_o <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         endcase
      end
   end

   AST_RX_VALID_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(st_q == RX_STOP)) else $error("byte without stop bit"); // R2
endmodule

// File: rtl/uq_uart_tx.sv
module uq_uart_tx #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_i,
   input  logic [7:0]       data_i,
   input  logic             valid_i,
   output logic             ready_o,
   output logic             line_o
);
   logic             busy_q;
   logic [9:0]       sh_q;
   logic [3:0]       nb_q;
   logic [DIV_W-1:0] cnt_q;

   assign ready_o = !busy_q;
   assign line_o  = busy_q ? sh_q[0] : 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         nb_q   <= '0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (valid_i) begin
            sh_q   <= {1'b1, data_i, 1'b0};
            nb_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end
      end else if (cnt_q == div_i - 1'b1) begin
         cnt_q <= '0;
         sh_q  <= {1'b1, sh_q[9:1]};
         nb_q  <= nb_q + 1'b1;
         if (nb_q == 4'd9) busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ready_o) |=> !line_o) else $error("no start bit"); // R1
endmodule

// File: rtl/uq_slip_dec.sv
module uq_slip_dec
   import uq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] byte_i,
   input  logic       byte_valid_i,
   output logic [7:0] data_o,
   output logic       valid_o,
   output logic       eof_o,
   output logic       query_o
);
   logic esc_q;
   logic body_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esc_q   <= 1'b0;
         body_q  <= 1'b0;
         data_o  <= '0;
         valid_o <= 1'b0;
         eof_o   <= 1'b0;
         query_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         eof_o   <= 1'b0;
         query_o <= 1'b0;
         if (byte_valid_i) begin
            if (byte_i == SLIP_END) begin
               query_o <= 1'b1;
               eof_o   <= body_q;
               body_q  <= 1'b0;
               esc_q   <= 1'b0;
            end else if (esc_q) begin
               esc_q   <= 1'b0;
               body_q  <= 1'b1;
               valid_o <= 1'b1;
               data_o  <= (byte_i == SLIP_ESC_END) ? SLIP_END :
                          (byte_i == SLIP_ESC_ESC) ? SLIP_ESC : byte_i;
            end else if (byte_i == SLIP_ESC) begin
               esc_q <= 1'b1;
            end else begin
               body_q  <= 1'b1;
               valid_o <= 1'b1;
               data_o  <= byte_i;
            end
         end
      end
   end

   AST_EOF_NEEDS_BODY: assert property (@(posedge clk) disable iff (!rst_n)
      eof_o |-> query_o) else $error("frame end without end token"); // R2
endmodule

// File: rtl/uq_reply_queue.sv
module uq_reply_queue
   import uq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int QMAX  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] in_data_i,
   input  logic       in_valid_i,
   input  logic       in_last_i,
   output logic       drop_o,
   input  logic       query_i,
   output logic [7:0] u_data_o,
   output logic       u_valid_o,
   input  logic       u_ready_i
);
   localparam int AW = $clog2(DEPTH);
   localparam int QW = $clog2(QMAX + 1);
   localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
   localparam logic [QW-1:0] QTOP = QW'(QMAX);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uq_reply_queue: DEPTH must be a power of two of at least 2");
   end
   if (QMAX < 1) begin : g_bad_qmax
      $error("uq_reply_queue: QMAX must be at least 1");
   end

   logic [8:0]  mem [DEPTH];
   logic [AW:0] wr_q, cm_q, rd_q, used;
   logic [AW:0] nfr_q;
   logic        drop_q;
   logic        fr_inc, fr_dec;
   logic [QW-1:0] qcnt_q;
   logic        take;
   reply_st_t   st_q;
   logic [8:0]  head;
   logic        head_spec;
   logic        hs;

   assign used = wr_q - rd_q;

   // write side: whole-frame commit, whole-frame drop
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q   <= '0;
         cm_q   <= '0;
         drop_q <= 1'b0;
         drop_o <= 1'b0;
      end else begin
         drop_o <= 1'b0;
         if (in_valid_i) begin
            if (drop_q) begin
               if (in_last_i) begin
                  drop_q <= 1'b0;
                  drop_o <= 1'b1;
               end
            end else if (used < FULL) begin
               wr_q <= wr_q + 1'b1;
               if (in_last_i) cm_q <= wr_q + 1'b1;
            end else begin
               wr_q <= cm_q;
               if (in_last_i) drop_o <= 1'b1;
               else           drop_q <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (in_valid_i && !drop_q && used < FULL)
         mem[wr_q[AW-1:0]] <= {in_last_i, in_data_i};
   end

   assign fr_inc = in_valid_i && !drop_q && (used < FULL) && in_last_i;

   always_ff @(posedge clk) begin
      if (!rst_n)                nfr_q <= '0;
      else if (fr_inc && !fr_dec) nfr_q <= nfr_q + 1'b1;
      else if (!fr_inc && fr_dec) nfr_q <= nfr_q - 1'b1;
   end

   // query counter, saturating
   assign take = (st_q == RP_IDLE) && (qcnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         qcnt_q <= '0;
      end else begin
         case ({query_i && (qcnt_q != QTOP), take})
            2'b10:   qcnt_q <= qcnt_q + 1'b1;
            2'b01:   qcnt_q <= qcnt_q - 1'b1;
            default: qcnt_q <= qcnt_q;
         endcase
      end
   end

   // reply engine with SLIP encoding
   assign head      = mem[rd_q[AW-1:0]];
   assign head_spec = (head[7:0] == SLIP_END) || (head[7:0] == SLIP_ESC);
   assign hs        = u_valid_o && u_ready_i;

   always_comb begin
      u_valid_o = 1'b1;
      case (st_q)
         RP_DATA: u_data_o = head_spec ? SLIP_ESC : head[7:0];
         RP_ESC:  u_data_o = (head[7:0] == SLIP_END) ? SLIP_ESC_END : SLIP_ESC_ESC;
         RP_END:  u_data_o = SLIP_END;
         default: begin
            u_data_o  = SLIP_END;
            u_valid_o = 1'b0;
         end
      endcase
   end

   assign fr_dec = hs && head[8] &&
                   ((st_q == RP_ESC) || (st_q == RP_DATA && !head_spec));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= RP_IDLE;
         rd_q <= '0;
      end else begin
         case (st_q)
            RP_IDLE: begin
               if (take) st_q <= (nfr_q != '0) ? RP_DATA : RP_END;
            end
            RP_DATA: begin
               if (hs) begin
                  if (head_spec) begin
                     st_q <= RP_ESC;
                  end else begin
                     rd_q <= rd_q + 1'b1;
                     if (head[8]) st_q <= RP_END;
                  end
               end
            end
            RP_ESC: begin
               if (hs) begin
                  rd_q <= rd_q + 1'b1;
                  st_q <= head[8] ? RP_END : RP_DATA;
               end
            end
            default: begin
               if (hs) st_q <= RP_IDLE;
            end
         endcase
      end
   end

   AST_QCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      qcnt_q <= QTOP) else $error("query count past limit"); // R7
   AST_READ_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == RP_DATA || st_q == RP_ESC) |-> (nfr_q != '0)) else $error("reading open frame"); // R6
   AST_DROP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> $past(in_valid_i && in_last_i)) else $error("drop pulse off frame end"); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      used <= FULL) else $error("buffer overrun"); // R8
   AST_REPLY_NEEDS_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != RP_IDLE && $past(st_q) == RP_IDLE) |-> $past(qcnt_q != '0)) else $error("unsolicited reply"); // R3
endmodule

// File: rtl/uart2_query_port.sv
module uart2_query_port #(
   parameter int DIV_W       = 16,
   parameter int DEPTH       = 64,
   parameter int QMAX        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             rx_line_i,
   output logic             tx_line_o,
   output logic [7:0]       rcv_data_o,
   output logic             rcv_valid_o,
   output logic             rcv_eof_o,
   input  logic [7:0]       snd_data_i,
   input  logic             snd_valid_i,
   input  logic             snd_last_i,
   output logic             snd_drop_o
);
   if (DIV_W < 3) begin : g_bad_div
      $error("uart2_query_port: DIV_W must be at least 3");
   end

   logic [7:0] rx_byte;
   logic       rx_byte_v;
   logic       query;
   logic [7:0] u_data;
   logic       u_valid;
   logic       u_ready;

   uq_uart_rx #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_i   (baud_div),
      .line_i  (rx_line_i),
      .data_o  (rx_byte),
      .valid_o (rx_byte_v)
   );

   uq_slip_dec i_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .byte_i       (rx_byte),
      .byte_valid_i (rx_byte_v),
      .data_o       (rcv_data_o),
      .valid_o      (rcv_valid_o),
      .eof_o        (rcv_eof_o),
      .query_o      (query)
   );

   uq_reply_queue #(.DEPTH(DEPTH), .QMAX(QMAX)) i_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_data_i  (snd_data_i),
      .in_valid_i (snd_valid_i),
      .in_last_i  (snd_last_i),
      .drop_o     (snd_drop_o),
      .query_i    (query),
      .u_data_o   (u_data),
      .u_valid_o  (u_valid),
      .u_ready_i  (u_ready)
   );

   uq_uart_tx #(.DIV_W(DIV_W)) i_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_i   (baud_div),
      .data_i  (u_data),
      .valid_i (u_valid),
      .ready_o (u_ready),
      .line_o  (tx_line_o)
   );

   AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      baud_div >= DIV_W'(4)) else $error("bit period too short"); // R10
endmodule

// File: tb/test_uart2_query_port.sv
module test_uart2_query_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] baud = 16'd8;
   logic        rx_line = 1'b1;
   logic        tx_line;
   logic [7:0]  rcv_data;
   logic        rcv_valid, rcv_eof;
   logic [7:0]  snd_data = '0;
   logic        snd_valid = 1'b0, snd_last = 1'b0;
   logic        snd_drop;

   int checks = 0, failures = 0;
   logic [7:0] got [0:255];
   int ngot = 0;
   logic [7:0] rcvd [0:255];
   int nrcv = 0, neof = 0, ndrop = 0;
   logic [7:0] ex [0:63];
   int nex = 0;

   always #10 clk = ~clk;

   uart2_query_port #(.DIV_W(16), .DEPTH(16), .QMAX(2), .SYNC_STAGES(2)) i_uart2_query_port (
      .clk(clk), .rst_n(rst_n), .baud_div(baud),
      .rx_line_i(rx_line), .tx_line_o(tx_line),
      .rcv_data_o(rcv_data), .rcv_valid_o(rcv_valid), .rcv_eof_o(rcv_eof),
      .snd_data_i(snd_data), .snd_valid_i(snd_valid), .snd_last_i(snd_last),
      .snd_drop_o(snd_drop)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // collector of bytes sent by the block
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx_line == 1'b0) begin
            logic [7:0] b;
            repeat (int'(baud) / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               repeat (int'(baud)) @(negedge clk);
               b[i] = tx_line;
            end
            repeat (int'(baud)) @(negedge clk);
            check("R1 stop bit", int'(tx_line), 1);
            got[ngot] = b;
            ngot++;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (rcv_valid) begin rcvd[nrcv] = rcv_data; nrcv++; end
         if (rcv_eof) neof++;
         if (snd_drop) ndrop++;
      end
   end

   task automatic ep_byte(input logic [7:0] b);
      @(negedge clk);
      rx_line = 1'b0;
      repeat (int'(baud)) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_line = b[i];
         repeat (int'(baud)) @(negedge clk);
      end
      rx_line = 1'b1;
      repeat (int'(baud)) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b, input logic last);
      @(negedge clk);
      snd_data = b; snd_valid = 1'b1; snd_last = last;
      @(negedge clk);
      snd_valid = 1'b0; snd_last = 1'b0;
   endtask

   task automatic exp_add(input logic [7:0] b);
      ex[nex] = b;
      nex++;
   endtask

   task automatic check_reply(input string req);
      check({req, " reply length"}, ngot, nex);
      for (int i = 0; i < nex && i < ngot; i++)
         check({req, " reply byte"}, int'(got[i]), int'(ex[i]));
      ngot = 0;
      nex = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R9 tx idle high", int'(tx_line), 1);
      check("R9 rcv_valid low", int'(rcv_valid), 0);
      check("R9 eof low", int'(rcv_eof), 0);
      check("R9 drop low", int'(snd_drop), 0);
   endtask

   task automatic t_empty_query;
      ngot = 0;
      ep_byte(8'hC0);
      settle(400);
      exp_add(8'hC0);
      check_reply("R5 empty query");
      check("R3 raw end is no frame", neof, 0);
   endtask

   task automatic t_frame_reply;
      push(8'h11, 1'b0); push(8'hC0, 1'b0); push(8'h22, 1'b0); push(8'hDB, 1'b1);
      ngot = 0;
      ep_byte(8'hC0);
      settle(900);
      exp_add(8'h11); exp_add(8'hDB); exp_add(8'hDC); exp_add(8'h22);
      exp_add(8'hDB); exp_add(8'hDD); exp_add(8'hC0);
      check_reply("R4 escaped frame");
   endtask

   task automatic t_rx_decode;
      nrcv = 0; neof = 0; ngot = 0;
      ep_byte(8'h05); ep_byte(8'hDB); ep_byte(8'hDC);
      ep_byte(8'hDB); ep_byte(8'hDD); ep_byte(8'hC0);
      settle(400);
      check("R2 rx count", nrcv, 3);
      check("R2 rx byte0", int'(rcvd[0]), 'h05);
      check("R2 rx byte1", int'(rcvd[1]), 'hC0);
      check("R2 rx byte2", int'(rcvd[2]), 'hDB);
      check("R2 eof count", neof, 1);
      exp_add(8'hC0);
      check_reply("R3 escaped end is no query");
   endtask

   task automatic t_partial;
      push(8'h61, 1'b0); push(8'h62, 1'b0);
      ngot = 0;
      ep_byte(8'hC0);
      settle(400);
      exp_add(8'hC0);
      check_reply("R6 open frame held");
      push(8'h63, 1'b1);
      ep_byte(8'hC0);
      settle(600);
      exp_add(8'h61); exp_add(8'h62); exp_add(8'h63); exp_add(8'hC0);
      check_reply("R6 frame after close");
   endtask

   task automatic t_queries;
      for (int i = 0; i < 6; i++) push(8'h31 + 8'(i), i == 5);
      push(8'h42, 1'b1);
      ngot = 0;
      for (int i = 0; i < 4; i++) ep_byte(8'hC0);
      settle(1500);
      for (int i = 0; i < 6; i++) exp_add(8'h31 + 8'(i));
      exp_add(8'hC0); exp_add(8'h42); exp_add(8'hC0); exp_add(8'hC0);
      check_reply("R7 R11 queued queries in order");
   endtask

   task automatic t_overflow;
      ndrop = 0;
      for (int i = 0; i < 20; i++) push(8'h50 + 8'(i), i == 19);
      settle(4);
      check("R8 drop pulses", ndrop, 1);
      push(8'h77, 1'b0); push(8'h78, 1'b1);
      ngot = 0;
      ep_byte(8'hC0);
      settle(500);
      exp_add(8'h77); exp_add(8'h78); exp_add(8'hC0);
      check_reply("R8 later frame intact");
      ep_byte(8'hC0);
      settle(300);
      exp_add(8'hC0);
      check_reply("R8 dropped frame gone");
   endtask

   task automatic t_baud_change;
      baud = 16'd12;
      settle(4);
      push(8'hC0, 1'b1);
      ngot = 0;
      ep_byte(8'hC0);
      settle(700);
      exp_add(8'hDB); exp_add(8'hDC); exp_add(8'hC0);
      check_reply("R10 new bit period");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_empty_query;
      t_frame_reply;
      t_rx_decode;
      t_partial;
      t_queries;
      t_overflow;
      t_baud_change;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule